// File: doc/BRIEF.md
# Multi-Requester Cache Maintenance Command Front-End

This block lets several processors share one set of cache maintenance command registers. Each access on its memory-mapped register bus carries a requester ID. A requester takes the command registers by writing the mode register while nobody else holds them. It then fills in the address, size, mask and way registers. It gives them back by reading its own registration-status register. While one requester holds the registers, writes from any other requester are refused, and a private failure flag is set for the refused requester.

A successful status read hands the finished command word, tagged with the requester ID, to a downstream operation queue. When the queue has no room, the status read reports "full" and nothing is handed over. The queue later reports completions by requester ID. Each requester then sees its own busy, error and end-of-operation flags in a banked queue-status register. Bus reads are combinational. Every state change takes effect at the rising clock edge that ends the access.

Top module: `maint_cmd_frontend`

## Requirements
- R1: After reset no requester holds the command registers, every shared register reads 0, every queue-status register reads 0 and q_push is low.
- R2: A write to the mode register (offset 0x248) while no one holds the registers grants the right to the writer. While the right is held, any write from another requester to offsets 0x248–0x258 is refused. A refused write leaves the register contents unchanged and sets that requester's failure flag.
- R3: A write to the address (0x24C), size (0x250), mask (0x254) or way (0x258) register while no one holds the right is refused and sets the writer's failure flag.
- R4: A read of the registration status (0x25C) returns bit 0 = 1 if the reader has its failure flag set or does not hold the right. Otherwise it returns bit 1 = 1 if q_push_ready is low, and 0 on success. The read releases the right if the reader holds it, and clears the reader's failure flag.
- R5: A successful status read raises q_push during that access and presents the mode, address, size, mask and way fields, with q_req equal to the reader's ID. No other access raises q_push.
- R6: In a pushed command, address, size and mask are 0 unless the mode's scope field (bits 18:17) is 0 (address range). The way field is 0 unless the target field (bits 22:21) is 2 (by way).
- R7: The registration-status and queue-status registers are banked. Each requester reads only its own flags.
- R8: Queue status (0x260) bit 0 is 1 while the requester has pushed commands with no matching completion (cpl_valid with cpl_id equal to its ID).
- R9: Queue status bit 2 (end) is set by a completion for the requester when its most recent pushed mode had bit 15 set. Writing 1 to bit 2 clears it, and a completion in the same cycle wins over the clear.
- R10: Queue status bit 1 (error) is set by a completion with cpl_err high. Writing 1 to bit 1 clears it.
- R11: Any requester can read back the shared registers at 0x248, 0x24C, 0x250, 0x254 and 0x258.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_id | input | REQ_W | Requester ID of the access |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| q_push | output | 1 | Command handed to the queue |
| q_push_ready | input | 1 | Queue has room |
| q_req | output | REQ_W | Requester ID of pushed command |
| q_mode | output | 32 | Pushed mode word |
| q_addr | output | 32 | Pushed start address |
| q_size | output | 32 | Pushed size |
| q_mask | output | 32 | Pushed address mask |
| q_ways | output | 32 | Pushed way number |
| cpl_valid | input | 1 | Operation completion |
| cpl_id | input | REQ_W | Requester of completed operation |
| cpl_err | input | 1 | Completion ended in error |

## Verification
The bench builds the block with four requesters and a pending-count depth of four. With four requesters there is an owner, a contending requester that gets refused, and a third requester whose banked status must stay untouched. The small depth keeps the pending counters narrow. Holding q_push_ready low on demand reaches the queue-full branch. Separate scenarios cover a range command with notification and a by-way, whole-cache command without it, so both field-shaping branches and both end-flag cases are driven.

// File: rtl/maint_fe_pkg.sv
package maint_fe_pkg;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 12;

  localparam logic [OFS_W-1:0] OFS_MODE  = 12'h248;
  localparam logic [OFS_W-1:0] OFS_ADDR  = 12'h24C;
  localparam logic [OFS_W-1:0] OFS_SIZE  = 12'h250;
  localparam logic [OFS_W-1:0] OFS_MASK  = 12'h254;
  localparam logic [OFS_W-1:0] OFS_WAY   = 12'h258;
  localparam logic [OFS_W-1:0] OFS_REGST = 12'h25C;
  localparam logic [OFS_W-1:0] OFS_QST   = 12'h260;

  localparam int TGT_LO     = 21;
  localparam int SCOPE_LO   = 17;
  localparam int NOTIFY_BIT = 15;

  localparam logic [1:0] SCOPE_RANGE = 2'd0;
  localparam logic [1:0] TGT_BY_WAY  = 2'd2;

  typedef struct packed {
    logic [DATA_W-1:0] mode;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] size;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] ways;
  } cmd_t;

  function automatic logic [1:0] f_scope(input logic [DATA_W-1:0] m);
    return m[SCOPE_LO +: 2];
  endfunction

  function automatic logic [1:0] f_target(input logic [DATA_W-1:0] m);
    return m[TGT_LO +: 2];
  endfunction

  function automatic logic f_notify(input logic [DATA_W-1:0] m);
    return m[NOTIFY_BIT];
  endfunction

  function automatic logic f_is_shared(input logic [OFS_W-1:0] o);
    return (o == OFS_MODE) || (o == OFS_ADDR) || (o == OFS_SIZE) ||
           (o == OFS_MASK) || (o == OFS_WAY);
  endfunction

  // Zero the fields the selected scope and target do not use.
  function automatic cmd_t f_shape(input cmd_t c);
    cmd_t r;
    r = c;
    if (f_scope(c.mode) != SCOPE_RANGE) begin
      r.addr = '0;
      r.size = '0;
      r.mask = '0;
    end
    if (f_target(c.mode) != TGT_BY_WAY) r.ways = '0;
    return r;
  endfunction
endpackage

// File: rtl/maint_fe_owner.sv
module maint_fe_owner
  import maint_fe_pkg::*;
#(
  parameter int REQ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [REQ_W-1:0] wr_id,
  input  logic [DATA_W-1:0] wr_data,
  input  logic             release_en,
  output logic             own_valid,
  output logic [REQ_W-1:0] own_id,
  output cmd_t             cmd,
  output logic             refuse
);
  logic claim;
  logic accept;

  always_comb begin
    claim  = wr_en && !own_valid && (wr_ofs == OFS_MODE);
    refuse = wr_en && ((own_valid && (wr_id != own_id)) ||
                       (!own_valid && (wr_ofs != OFS_MODE)));
    accept = wr_en && own_valid && (wr_id == own_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_valid <= 1'b0;
      own_id    <= '0;
      cmd       <= '0;
    end else begin
      if (claim) begin
        own_valid <= 1'b1;
        own_id    <= wr_id;
        cmd       <= '0;
        cmd.mode  <= wr_data;
      end else if (accept) begin
        case (wr_ofs)
          OFS_MODE: cmd.mode <= wr_data;
          OFS_ADDR: cmd.addr <= wr_data;
          OFS_SIZE: cmd.size <= wr_data;
          OFS_MASK: cmd.mask <= wr_data;
          OFS_WAY:  cmd.ways <= wr_data;
          default:  ;
        endcase
      end
      if (release_en) own_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/maint_fe_bank.sv
module maint_fe_bank #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_fail,
  input  logic clr_fail,
  input  logic push,
  input  logic push_notify,
  input  logic cpl,
  input  logic cpl_err,
  input  logic clr_end,
  input  logic clr_err,
  output logic fail,
  output logic busy,
  output logic end_flag,
  output logic err_flag
);
  logic [PEND_W-1:0] pend;
  logic              notify_last;

  assign busy = (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail        <= 1'b0;
      pend        <= '0;
      notify_last <= 1'b0;
      end_flag    <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      if (set_fail) fail <= 1'b1;
      else if (clr_fail) fail <= 1'b0;

      if (push && !cpl) pend <= pend + 1'b1;
      else if (cpl && !push && busy) pend <= pend - 1'b1;

      if (push) notify_last <= push_notify;

      if (cpl && notify_last) end_flag <= 1'b1;
      else if (clr_end) end_flag <= 1'b0;

      if (cpl && cpl_err) err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/maint_cmd_frontend.sv
module maint_cmd_frontend
  import maint_fe_pkg::*;
#(
  parameter int N_REQ   = 4,
  parameter int Q_DEPTH = 8,
  localparam int REQ_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [REQ_W-1:0]  bus_id,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              q_push,
  input  logic              q_push_ready,
  output logic [REQ_W-1:0]  q_req,
  output logic [DATA_W-1:0] q_mode,
  output logic [DATA_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_size,
  output logic [DATA_W-1:0] q_mask,
  output logic [DATA_W-1:0] q_ways,
  input  logic              cpl_valid,
  input  logic [REQ_W-1:0]  cpl_id,
  input  logic              cpl_err
);
  localparam int PEND_W = $clog2(Q_DEPTH + 1);

  // Named internal events
  logic             shared_wr;
  logic             regst_rd;
  logic             qst_wr;
  logic             own_valid;
  logic [REQ_W-1:0] own_id;
  logic             refuse;
  logic             is_owner;
  logic             reg_fail;
  logic             reg_full;
  logic             release_en;
  cmd_t             cmd;
  cmd_t             shaped;

  logic [N_REQ-1:0] fail_v, busy_v, end_v, err_v;

  always_comb begin
    shared_wr  = bus_valid && bus_write && f_is_shared(bus_addr);
    regst_rd   = bus_valid && !bus_write && (bus_addr == OFS_REGST);
    qst_wr     = bus_valid && bus_write && (bus_addr == OFS_QST);
    is_owner   = own_valid && (own_id == bus_id);
    reg_fail   = fail_v[bus_id] || !is_owner;
    reg_full   = !reg_fail && !q_push_ready;
    release_en = regst_rd && is_owner;
    q_push     = regst_rd && !reg_fail && q_push_ready;
  end

  maint_fe_owner #(.REQ_W(REQ_W)) u_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (shared_wr),
    .wr_ofs    (bus_addr),
    .wr_id     (bus_id),
    .wr_data   (bus_wdata),
    .release_en(release_en),
    .own_valid (own_valid),
    .own_id    (own_id),
    .cmd       (cmd),
    .refuse    (refuse)
  );

  assign shaped = f_shape(cmd);
  assign q_req  = bus_id;
  assign q_mode = shaped.mode;
  assign q_addr = shaped.addr;
  assign q_size = shaped.size;
  assign q_mask = shaped.mask;
  assign q_ways = shaped.ways;

  for (genvar i = 0; i < N_REQ; i++) begin : g_bank
    logic sel;
    assign sel = (bus_id == REQ_W'(i));
    maint_fe_bank #(.PEND_W(PEND_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_fail   (refuse && sel),
      .clr_fail   (regst_rd && sel),
      .push       (q_push && sel),
      .push_notify(f_notify(cmd.mode)),
      .cpl        (cpl_valid && (cpl_id == REQ_W'(i))),
      .cpl_err    (cpl_err),
      .clr_end    (qst_wr && sel && bus_wdata[2]),
      .clr_err    (qst_wr && sel && bus_wdata[1]),
      .fail       (fail_v[i]),
      .busy       (busy_v[i]),
      .end_flag   (end_v[i]),
      .err_flag   (err_v[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        OFS_MODE:  bus_rdata = cmd.mode;
        OFS_ADDR:  bus_rdata = cmd.addr;
        OFS_SIZE:  bus_rdata = cmd.size;
        OFS_MASK:  bus_rdata = cmd.mask;
        OFS_WAY:   bus_rdata = cmd.ways;
        OFS_REGST: bus_rdata = {{(DATA_W-2){1'b0}}, reg_full, reg_fail};
        OFS_QST:   bus_rdata = {{(DATA_W-3){1'b0}}, end_v[bus_id],
                                err_v[bus_id], busy_v[bus_id]};
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/maint_fe_chk.sv
module maint_fe_chk
  import maint_fe_pkg::*;
#(
  parameter int REQ_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [REQ_W-1:0]  bus_id,
  input logic [OFS_W-1:0]  bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              own_valid,
  input logic [REQ_W-1:0]  own_id,
  input logic              q_push,
  input logic              q_push_ready,
  input logic [DATA_W-1:0] q_mode,
  input logic [DATA_W-1:0] q_addr,
  input logic [DATA_W-1:0] q_size,
  input logic [DATA_W-1:0] q_ways
);
  // R2: a mode write into an idle register set grants the writer
  a_r2_claim: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && (bus_addr == OFS_MODE) && !own_valid
    |=> own_valid && (own_id == $past(bus_id)));

  // R2: another requester's write never moves the right
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && own_valid && (bus_id != own_id)
    |=> own_valid && $stable(own_id));

  // R4: owner's status read gives the right back
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && (bus_addr == OFS_REGST) && own_valid &&
    (bus_id == own_id) |=> !own_valid);

  // R4: a push always reads back as success
  a_r4_success_zero: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (bus_rdata[1:0] == 2'b00));

  // R5: push only during a status read with room downstream
  a_r5_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> q_push_ready && bus_valid && !bus_write &&
               (bus_addr == OFS_REGST));

  // R6: non-range scope carries no address or size
  a_r6_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    q_push && (q_mode[SCOPE_LO +: 2] != SCOPE_RANGE)
    |-> (q_addr == '0) && (q_size == '0));

  // R6: way field only for by-way target
  a_r6_way_zero: assert property (@(posedge clk) disable iff (!rst_n)
    q_push && (q_mode[TGT_LO +: 2] != TGT_BY_WAY) |-> (q_ways == '0));
endmodule

bind maint_cmd_frontend maint_fe_chk #(.REQ_W(REQ_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_id      (bus_id),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .own_valid   (own_valid),
  .own_id      (own_id),
  .q_push      (q_push),
  .q_push_ready(q_push_ready),
  .q_mode      (q_mode),
  .q_addr      (q_addr),
  .q_size      (q_size),
  .q_ways      (q_ways)
);

// File: tb/test_maint_cmd_frontend.sv
module test_maint_cmd_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int N_REQ = 4;
  localparam int REQ_W = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_id = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        q_push;
  logic        q_push_ready = 1'b1;
  logic [1:0]  q_req;
  logic [31:0] q_mode, q_addr, q_size, q_mask, q_ways;
  logic        cpl_valid = 1'b0;
  logic [1:0]  cpl_id = '0;
  logic        cpl_err = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // captured by read task
  logic [31:0] rd;
  logic        pushed;
  logic [1:0]  p_req;
  logic [31:0] p_mode, p_addr, p_size, p_mask, p_ways;

  always #(CLK_PERIOD/2) clk = ~clk;

  maint_cmd_frontend #(.N_REQ(N_REQ), .Q_DEPTH(4)) i_maint_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_id(bus_id), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .q_push(q_push), .q_push_ready(q_push_ready),
    .q_req(q_req), .q_mode(q_mode), .q_addr(q_addr), .q_size(q_size),
    .q_mask(q_mask), .q_ways(q_ways), .cpl_valid(cpl_valid),
    .cpl_id(cpl_id), .cpl_err(cpl_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] id, input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_id = id; bus_addr = ofs; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] id, input logic [11:0] ofs);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_id = id; bus_addr = ofs;
    #1;
    rd = bus_rdata; pushed = q_push; p_req = q_req; p_mode = q_mode;
    p_addr = q_addr; p_size = q_size; p_mask = q_mask; p_ways = q_ways;
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic complete(input logic [1:0] id, input logic err);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_id = id; cpl_err = err;
    @(posedge clk); #1;
    cpl_valid = 1'b0; cpl_err = 1'b0;
  endtask

  task automatic t_reset;
    rdreg(2'd0, 12'h248); check("R1 mode reads zero", rd, 32'h0);
    check("R1 no push", {31'b0, pushed}, 32'h0);
    for (int i = 0; i < N_REQ; i++) begin
      rdreg(2'(i), 12'h260); check("R1 queue status zero", rd, 32'h0);
    end
  endtask

  task automatic t_claim_and_push;
    wr(2'd1, 12'h248, 32'h0000_8002);   // range, LRU data, notify, flush
    wr(2'd1, 12'h24C, 32'h0000_1000);
    wr(2'd1, 12'h250, 32'h0000_0040);
    wr(2'd1, 12'h254, 32'h0000_0FFF);
    wr(2'd1, 12'h258, 32'h0000_000F);
    wr(2'd2, 12'h248, 32'h0000_0001);   // refused contender
    wr(2'd2, 12'h24C, 32'h0000_9999);   // refused
    rdreg(2'd0, 12'h248); check("R2 R11 mode kept after refusal", rd, 32'h0000_8002);
    rdreg(2'd3, 12'h24C); check("R2 R11 addr kept after refusal", rd, 32'h0000_1000);
    rdreg(2'd0, 12'h258); check("R11 way readback", rd, 32'h0000_000F);
    rdreg(2'd2, 12'h25C); check("R4 contender fails", rd, 32'h1);
    check("R5 no push on failure", {31'b0, pushed}, 32'h0);
    rdreg(2'd1, 12'h25C); check("R4 owner success", rd, 32'h0);
    check("R5 push on success", {31'b0, pushed}, 32'h1);
    check("R5 q_req", {30'b0, p_req}, 32'h1);
    check("R5 mode", p_mode, 32'h0000_8002);
    check("R6 range addr kept", p_addr, 32'h0000_1000);
    check("R6 range size kept", p_size, 32'h0000_0040);
    check("R6 range mask kept", p_mask, 32'h0000_0FFF);
    check("R6 way zeroed", p_ways, 32'h0);
    rdreg(2'd1, 12'h260); check("R8 busy after push", rd, 32'h1);
    rdreg(2'd2, 12'h260); check("R7 other bank idle", rd, 32'h0);
    rdreg(2'd1, 12'h25C); check("R4 released, not owner", rd, 32'h1);
    complete(2'd1, 1'b0);
    rdreg(2'd1, 12'h260); check("R9 end set, R8 idle", rd, 32'h4);
    rdreg(2'd0, 12'h260); check("R7 bank0 untouched", rd, 32'h0);
    wr(2'd1, 12'h260, 32'h4);
    rdreg(2'd1, 12'h260); check("R9 end cleared", rd, 32'h0);
  endtask

  task automatic t_unowned_write;
    wr(2'd3, 12'h250, 32'h0000_0080);
    rdreg(2'd0, 12'h250); check("R3 size unchanged", rd, 32'h0000_0040);
    rdreg(2'd3, 12'h25C); check("R3 writer flagged", rd, 32'h1);
    check("R3 no push", {31'b0, pushed}, 32'h0);
  endtask

  task automatic t_full_then_way;
    // scope all, target by way, touch, no notify
    q_push_ready = 1'b0;
    wr(2'd0, 12'h248, 32'h0042_0005);
    wr(2'd0, 12'h24C, 32'h0000_0055);
    wr(2'd0, 12'h258, 32'h0000_0003);
    rdreg(2'd0, 12'h25C); check("R4 queue full", rd, 32'h2);
    check("R5 no push when full", {31'b0, pushed}, 32'h0);
    q_push_ready = 1'b1;
    wr(2'd3, 12'h248, 32'h0042_0005);   // right was released: req3 claims
    wr(2'd3, 12'h24C, 32'h0000_0055);
    wr(2'd3, 12'h258, 32'h0000_0003);
    rdreg(2'd3, 12'h25C); check("R4 retry success", rd, 32'h0);
    check("R6 all-scope addr zero", p_addr, 32'h0);
    check("R6 all-scope size zero", p_size, 32'h0);
    check("R6 by-way ways kept", p_ways, 32'h3);
    check("R5 q_req retry", {30'b0, p_req}, 32'h3);
    complete(2'd3, 1'b1);
    rdreg(2'd3, 12'h260); check("R10 error set, R9 no end", rd, 32'h2);
    wr(2'd3, 12'h260, 32'h2);
    rdreg(2'd3, 12'h260); check("R10 error cleared", rd, 32'h0);
  endtask

  task automatic t_set_wins;
    wr(2'd2, 12'h248, 32'h0002_8000);   // all scope, notify, invalidate
    rdreg(2'd2, 12'h25C); check("R5 push req2", {31'b0, pushed}, 32'h1);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_id = 2'd2; bus_addr = 12'h260;
    bus_wdata = 32'h4; cpl_valid = 1'b1; cpl_id = 2'd2; cpl_err = 1'b0;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0; cpl_valid = 1'b0;
    rdreg(2'd2, 12'h260); check("R9 set beats clear", rd, 32'h4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_claim_and_push();
    t_unowned_write();
    t_full_then_way();
    t_set_wins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule